// File: doc/BRIEF.md
# Clock (Second-Chance) Victim Selector

This block chooses which line to evict from a fully associative cache, or from one set of a set-associative cache, holding `NUM_LINES` lines. For each line it holds a single "recently touched" flag, and it keeps a hand pointer that walks the lines in circular order. The tag and data arrays sit outside the block. The surrounding cache controller uses three inputs to report what happens. A fill event says that a line has just been written with a new block. A hit event says that an existing line was accessed. An eviction request asks for a victim.

After a request the hand sweeps forward by one line per clock. A line whose flag is set gets a second chance: its flag is cleared and the hand moves on. The first line found with a clear flag is the victim. Its index comes out with a one-cycle strobe, and the hand is left on the following line. When every flag starts out set, one full lap clears them all, so the search is finished by the first line of the second lap.

Top module: `clk_repl_top`

## Requirements
- R1: After reset `busy` and `victim_vld` are 0, every line's flag is 0 and the hand points at line 0. A request made right after reset therefore returns line 0 after one search cycle.
- R2: A fill event (`fill_vld`=1 with `fill_idx`) sets that line's flag to 1 at the next clock edge.
- R3: A hit event (`hit_vld`=1 with `hit_idx`) sets that line's flag to 1 at the next clock edge.
- R4: An eviction request is accepted at a clock edge while the block is idle. The block then examines one line per cycle, starting at the hand. `victim_vld` goes high k edges after the accepting edge, where k is the number of lines examined, and `victim_idx` names the first examined line whose flag was 0.
- R5: Each line that the sweep passes over because its flag was 1 has its flag cleared to 0.
- R6: Once a victim is chosen, the hand points at the line after it. After line `NUM_LINES`-1 it wraps to line 0.
- R7: If no fill or hit events arrive during the search, the search ends after at most `NUM_LINES`+1 examined lines.
- R8: If a hit or fill names the line under the hand in the same cycle that line is examined, the line is skipped as if its flag were 1, its flag remains 1, and the hand advances.
- R9: `victim_vld` is a single-cycle pulse. `busy` is 1 from the accepting edge up to the victim edge, and eviction requests made while `busy` is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_vld | input | 1 | A line was filled with a new block |
| fill_idx | input | IDX_W | Index of the filled line |
| hit_vld | input | 1 | A line was referenced |
| hit_idx | input | IDX_W | Index of the referenced line |
| evict_req | input | 1 | Request for a victim |
| busy | output | 1 | Search in progress |
| victim_vld | output | 1 | One-cycle strobe: victim chosen |
| victim_idx | output | IDX_W | Index of the chosen victim |

## Verification
The bench targets the full-lap case, where every flag is set: a design with an off-by-one in the wrap would return the wrong line or take a different number of cycles. It also checks that the hand resumes after the last victim rather than at line 0, which a design that reset the hand per search would get wrong. A hit that collides with the line under the hand must save that line; a design giving the sweep's clear priority would evict it then, or on a later lap. Extra requests made while busy must not produce a second strobe, and a reset in the middle of use must clear every flag.

// File: rtl/clk_repl_pkg.sv
package clk_repl_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_st_e;

    function automatic int unsigned idx_width(input int unsigned lines);
        return (lines > 1) ? $clog2(lines) : 1;
    endfunction

endpackage

// File: rtl/clk_repl_flags.sv
module clk_repl_flags #(
    parameter int unsigned NUM_LINES = 8,
    parameter int unsigned IDX_W     = clk_repl_pkg::idx_width(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fill_vld,
    input  logic [IDX_W-1:0]     fill_idx,
    input  logic                 hit_vld,
    input  logic [IDX_W-1:0]     hit_idx,
    input  logic                 clr_vld,
    input  logic [IDX_W-1:0]     clr_idx,
    output logic [NUM_LINES-1:0] flags_q
);

    logic [NUM_LINES-1:0] flags_d;

    // one flag cell per line; a set from fill or hit wins over the sweep clear
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic set_this;
        logic clr_this;
        always_comb begin
            set_this = (fill_vld && (fill_idx == IDX_W'(g)))
                    || (hit_vld  && (hit_idx  == IDX_W'(g)));
            clr_this = clr_vld && (clr_idx == IDX_W'(g));
            if (set_this) begin
                flags_d[g] = 1'b1;
            end else if (clr_this) begin
                flags_d[g] = 1'b0;
            end else begin
                flags_d[g] = flags_q[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    a_r2_fill_sets: assert property (@(posedge clk) disable iff (!rst_n)
        fill_vld |=> flags_q[$past(fill_idx)]);

    a_r3_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vld |=> flags_q[$past(hit_idx)]);

    a_r5_sweep_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vld && !(fill_vld && fill_idx == clr_idx) && !(hit_vld && hit_idx == clr_idx))
        |=> !flags_q[$past(clr_idx)]);

endmodule

// File: rtl/clk_repl_sweep.sv
module clk_repl_sweep
    import clk_repl_pkg::*;
#(
    parameter int unsigned NUM_LINES = 8,
    parameter int unsigned IDX_W     = clk_repl_pkg::idx_width(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] flags,
    input  logic                 fill_vld,
    input  logic [IDX_W-1:0]     fill_idx,
    input  logic                 hit_vld,
    input  logic [IDX_W-1:0]     hit_idx,
    input  logic                 evict_req,
    output logic                 clr_vld,
    output logic [IDX_W-1:0]     clr_idx,
    output logic                 busy,
    output logic                 victim_vld,
    output logic [IDX_W-1:0]     victim_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);
    localparam int unsigned      STEP_W   = IDX_W + 2;

    typedef struct packed {
        scan_st_e         st;
        logic [IDX_W-1:0] hand;
        logic             vld;
        logic [IDX_W-1:0] vidx;
    } sweep_s;

    sweep_s sw_d, sw_q;
    logic   touched;

    function automatic logic [IDX_W-1:0] step_hand(input logic [IDX_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + IDX_W'(1);
    endfunction

    always_comb begin
        touched = (hit_vld  && (hit_idx  == sw_q.hand))
               || (fill_vld && (fill_idx == sw_q.hand));
        sw_d     = sw_q;
        sw_d.vld = 1'b0;
        clr_vld  = 1'b0;
        clr_idx  = sw_q.hand;
        unique case (sw_q.st)
            ST_IDLE: begin
                if (evict_req) begin
                    sw_d.st = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (!touched && !flags[sw_q.hand]) begin
                    sw_d.vld  = 1'b1;
                    sw_d.vidx = sw_q.hand;
                    sw_d.st   = ST_IDLE;
                end else if (!touched) begin
                    clr_vld = 1'b1;
                end
                sw_d.hand = step_hand(sw_q.hand);
            end
            default: sw_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q <= '{st: ST_IDLE, hand: '0, vld: 1'b0, vidx: '0};
        end else begin
            sw_q <= sw_d;
        end
    end

    assign busy       = (sw_q.st == ST_SCAN);
    assign victim_vld = sw_q.vld;
    assign victim_idx = sw_q.vidx;

    // step counter used only by the bound check below
    logic [STEP_W-1:0] steps_q;
    logic              touch_seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n || sw_q.st == ST_IDLE) begin
            steps_q      <= '0;
            touch_seen_q <= 1'b0;
        end else begin
            steps_q      <= steps_q + STEP_W'(1);
            touch_seen_q <= touch_seen_q | touched;
        end
    end

    a_r7_scan_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !touch_seen_q) |-> (steps_q <= STEP_W'(NUM_LINES)));

    a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        victim_vld |=> !victim_vld);

    a_r9_strobe_ends_scan: assert property (@(posedge clk) disable iff (!rst_n)
        victim_vld |-> (!busy && $past(busy)));

    a_r6_hand_follows: assert property (@(posedge clk) disable iff (!rst_n)
        victim_vld |-> (sw_q.hand == step_hand(victim_idx)));

    a_r4_hand_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        sw_q.hand <= LAST_IDX);

endmodule

// File: rtl/clk_repl_top.sv
module clk_repl_top #(
    parameter int unsigned NUM_LINES = 8,
    parameter int unsigned IDX_W     = clk_repl_pkg::idx_width(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_vld,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             hit_vld,
    input  logic [IDX_W-1:0] hit_idx,
    input  logic             evict_req,
    output logic             busy,
    output logic             victim_vld,
    output logic [IDX_W-1:0] victim_idx
);

    logic [NUM_LINES-1:0] flags;
    logic                 clr_vld;
    logic [IDX_W-1:0]     clr_idx;

    clk_repl_flags #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_vld (fill_vld),
        .fill_idx (fill_idx),
        .hit_vld  (hit_vld),
        .hit_idx  (hit_idx),
        .clr_vld  (clr_vld),
        .clr_idx  (clr_idx),
        .flags_q  (flags)
    );

    clk_repl_sweep #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_sweep (
        .clk        (clk),
        .rst_n      (rst_n),
        .flags      (flags),
        .fill_vld   (fill_vld),
        .fill_idx   (fill_idx),
        .hit_vld    (hit_vld),
        .hit_idx    (hit_idx),
        .evict_req  (evict_req),
        .clr_vld    (clr_vld),
        .clr_idx    (clr_idx),
        .busy       (busy),
        .victim_vld (victim_vld),
        .victim_idx (victim_idx)
    );

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!busy && !victim_vld));

endmodule

// File: tb/clk_repl_top_tb.sv
module clk_repl_top_tb;

    localparam int unsigned N  = 4;
    localparam int unsigned IW = 2;
    localparam logic [1:0] OP_FILL  = 2'd0;
    localparam logic [1:0] OP_HIT   = 2'd1;
    localparam logic [1:0] OP_EVICT = 2'd2;
    localparam int unsigned NVEC = 14;

    // {op[9:8], idx[7:4], expected latency[3:0]}; for evict, idx is the expected victim
    localparam logic [9:0] VEC [0:NVEC-1] = '{
        {OP_EVICT, 4'd0, 4'd1},
        {OP_FILL,  4'd0, 4'd0},
        {OP_FILL,  4'd1, 4'd0},
        {OP_FILL,  4'd2, 4'd0},
        {OP_FILL,  4'd3, 4'd0},
        {OP_EVICT, 4'd1, 4'd5},
        {OP_HIT,   4'd3, 4'd0},
        {OP_EVICT, 4'd2, 4'd1},
        {OP_EVICT, 4'd0, 4'd2},
        {OP_HIT,   4'd1, 4'd0},
        {OP_HIT,   4'd2, 4'd0},
        {OP_EVICT, 4'd3, 4'd3},
        {OP_EVICT, 4'd0, 4'd1},
        {OP_HIT,   4'd0, 4'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fill_vld = 1'b0;
    logic [IW-1:0] fill_idx = '0;
    logic          hit_vld = 1'b0;
    logic [IW-1:0] hit_idx = '0;
    logic          evict_req = 1'b0;
    logic          busy;
    logic          victim_vld;
    logic [IW-1:0] victim_idx;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    clk_repl_top #(.NUM_LINES(N)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_vld   (fill_vld),
        .fill_idx   (fill_idx),
        .hit_vld    (hit_vld),
        .hit_idx    (hit_idx),
        .evict_req  (evict_req),
        .busy       (busy),
        .victim_vld (victim_vld),
        .victim_idx (victim_idx)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_fill(input int i);
        fill_vld = 1'b1;
        fill_idx = IW'(i);
        @(negedge clk);
        fill_vld = 1'b0;
    endtask

    task automatic do_hit(input int i);
        hit_vld = 1'b1;
        hit_idx = IW'(i);
        @(negedge clk);
        hit_vld = 1'b0;
    endtask

    // issue a request and wait for the strobe; checks victim, latency and pulse width
    task automatic do_evict(input int exp_idx, input int exp_lat, input string req);
        int lat;
        evict_req = 1'b1;
        @(negedge clk);
        evict_req = 1'b0;
        chk(busy == 1'b1, "R9 busy after accept", int'(busy), 1);
        lat = 0;
        while (!victim_vld && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk(victim_vld && int'(victim_idx) == exp_idx, req, int'(victim_idx), exp_idx);
        chk(lat == exp_lat, {req, " latency"}, lat, exp_lat);
        @(negedge clk);
        chk(!victim_vld && !busy, "R9 strobe one cycle", int'(victim_vld), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset and right after
        chk(!busy && !victim_vld, "R1 reset outputs", int'(busy) + int'(victim_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !victim_vld, "R1 idle after reset", int'(busy) + int'(victim_vld), 0);

        // table walk: R1 hand at 0, R2 fill, R3 hit, R4 first clear flag,
        // R5 sweep clears, R6 hand wraps after victim, R7 full lap of N+1
        for (int v = 0; v < NVEC; v++) begin
            unique case (VEC[v][9:8])
                OP_FILL:  do_fill(int'(VEC[v][7:4]));
                OP_HIT:   do_hit(int'(VEC[v][7:4]));
                default:  do_evict(int'(VEC[v][7:4]), int'(VEC[v][3:0]),
                                   "R4 R5 R6 R7 table victim");
            endcase
        end
        // hand now at 1; flags: line 0 set, others clear
        do_evict(1, 1, "R6 hand resumes after last victim");

        // R8: hit to the line under the hand in its examine cycle
        // hand=2 now, flags: line 0 set
        evict_req = 1'b1;
        @(negedge clk);
        evict_req = 1'b0;
        hit_vld = 1'b1;
        hit_idx = IW'(2);
        @(negedge clk);
        hit_vld = 1'b0;
        chk(!victim_vld, "R8 colliding line not chosen", int'(victim_vld), 0);
        @(negedge clk);
        chk(victim_vld && victim_idx == IW'(3), "R8 next line chosen", int'(victim_idx), 3);
        @(negedge clk);
        // hand=0, line0 set, line2 set (saved). Line0 cleared then 1 chosen
        do_evict(1, 2, "R8 R5 sweep over line 0");
        // hand=2: line 2 must still be set, so 3 is chosen after 2 steps
        do_evict(3, 2, "R8 flag kept after collision");

        // R9: extra request while busy ignored; all set gives full lap
        // hand=0, flags: 2 cleared above, 0 cleared -> fill all
        for (int i = 0; i < N; i++) do_fill(i);
        evict_req = 1'b1;
        @(negedge clk);
        evict_req = 1'b1;
        @(negedge clk);
        evict_req = 1'b0;
        begin
            int lat = 1;
            while (!victim_vld && lat < 20) begin
                @(negedge clk);
                lat++;
            end
            chk(victim_vld && victim_idx == IW'(0), "R7 full lap victim", int'(victim_idx), 0);
            chk(lat == 5, "R7 full lap latency", lat, 5);
        end
        begin
            int extra = 0;
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                if (victim_vld || busy) extra++;
            end
            chk(extra == 0, "R9 request while busy ignored", extra, 0);
        end

        // R1: reset in mid-use clears flags and hand
        for (int i = 0; i < N; i++) do_fill(i);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        do_evict(0, 1, "R1 flags and hand cleared by reset");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule